// File: doc/BRIEF.md
# Fractional-N Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio with quarter-step resolution. It takes a programming word that encodes four times the wanted ratio. The upper bits of the word are an integer ratio N and the two lowest bits are a fraction k. Every output period lasts either N or N+1 input cycles. A two-bit accumulator picks between them, so over any four periods the total is exactly 4N+k input cycles. That makes the average ratio N + k/4. The output is a one-cycle pulse on the last input cycle of each period, and it drives a phase detector.

The word arrives through a strobe. The strobe marks the cycle in which a bus transfer has fully completed. A word that passes the minimum check goes into a shadow register and is marked pending. The pending word becomes active only at a period boundary, and only while the charge-pump busy input is low. A busy boundary is skipped and the update waits for the next one. After reset the divider stays idle and produces no pulse until the first accepted word. That first word starts it in the first cycle in which busy is low. A test-enable input copies the divided pulse onto a monitor output.

Top module: `fracn_divider`

## Requirements
- R1: After reset, and until a word at or above MIN_WORD has been accepted, `divPulse` and `monOut` stay low.
- R2: The word is split with the ratio N in bits [WORD_W-1:FRAC_W] and the fraction k in bits [FRAC_W-1:0]. While a setting is active, every interval between consecutive `divPulse` pulses is N or N+1 input cycles.
- R3: While one setting stays active, any four consecutive pulse intervals add up to exactly the programmed word, 4N+k.
- R4: A write whose word is below MIN_WORD (default 2048) is ignored, and the active and pending settings are unchanged. A word equal to MIN_WORD is accepted.
- R5: A newly written setting never changes the current period. It takes effect at the next pulse after the write, and the first period of the new setting starts in the cycle after that pulse.
- R6: While `cpBusy` is high, the active setting does not change and an idle divider does not start. The pending update is applied at the first period boundary at which `cpBusy` is low.
- R7: `divPulse` is high for exactly one input cycle per period.
- R8: `monOut` equals `divPulse` while `testEn` is high and is low while `testEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock being divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrStrobe | input | 1 | One-cycle pulse marking a completed bus write |
| wrWord | input | INT_W+FRAC_W | Programmed word, 4N+k |
| cpBusy | input | 1 | High while the charge pump sources or sinks current |
| testEn | input | 1 | Routes the divided pulse to `monOut` |
| divPulse | output | 1 | One-cycle pulse at the end of each division period |
| monOut | output | 1 | Test monitor copy of `divPulse` |

## Verification
The bench builds the divider with INT_W=6, FRAC_W=2 and MIN_WORD=12. This keeps periods between 3 and 64 input cycles, so hundreds of periods fit in a short run. It also brings the largest word, N=63 with k=3, within reach, and that word exercises the extra counter bit needed for a period of N+1. The small minimum places the accept/ignore boundary at words 11 and 12. A behavioural model built on phase counting is compared with both outputs on every cycle. Directed sequences cover a write landing on a pulse, deferral under `cpBusy`, and every value of k.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic apply;    // load the shadow word this edge
    logic running;  // divider has been started
  } divStrobes_t;
endpackage

// File: rtl/fracn_ctrl.sv
module fracn_ctrl
  import fracn_pkg::*;
#(
  parameter int WORD_W   = 15,
  parameter int MIN_WORD = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStrobe,
  input  logic [WORD_W-1:0] wrWord,
  input  logic              cpBusy,
  input  logic              periodEnd,
  output divStrobes_t       strobes,
  output logic [WORD_W-1:0] shadowWord
);
  localparam logic [WORD_W-1:0] MinWord = WORD_W'(MIN_WORD);

  logic pending;
  logic running;
  logic wrOk;
  logic applyNow;

  assign wrOk     = wrStrobe && (wrWord >= MinWord);
  // Update only between periods (or before start) and with the pump idle
  assign applyNow = pending && !cpBusy && (!running || periodEnd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowWord <= '0;
      pending    <= 1'b0;
      running    <= 1'b0;
    end else begin
      if (wrOk) begin
        shadowWord <= wrWord;
        pending    <= 1'b1;
      end else if (applyNow) begin
        pending    <= 1'b0;
      end
      if (applyNow) running <= 1'b1;
    end
  end

  assign strobes.apply   = applyNow;
  assign strobes.running = running;
endmodule

// File: rtl/fracn_datapath.sv
module fracn_datapath
  import fracn_pkg::*;
#(
  parameter int INT_W  = 13,
  parameter int FRAC_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  divStrobes_t             strobes,
  input  logic [INT_W+FRAC_W-1:0] shadowWord,
  output logic                    periodEnd,
  output logic [INT_W+FRAC_W-1:0] activeWord
);
  localparam int WORD_W = INT_W + FRAC_W;
  localparam int CNT_W  = INT_W + 1;  // room for N+1 at the largest N

  logic [INT_W-1:0]  activeN;
  logic [FRAC_W-1:0] activeK;
  logic [FRAC_W-1:0] acc;
  logic [CNT_W-1:0]  cnt;

  logic [INT_W-1:0]  selN;
  logic [FRAC_W-1:0] selK;
  logic [FRAC_W-1:0] accNext;
  logic              carry;
  logic [CNT_W-1:0]  lenNext;

  assign selN = strobes.apply ? shadowWord[WORD_W-1:FRAC_W] : activeN;
  assign selK = strobes.apply ? shadowWord[FRAC_W-1:0]      : activeK;

  // Fraction accumulator: an overflow stretches the next period by one
  assign {carry, accNext} = {1'b0, acc} + {1'b0, selK};
  assign lenNext          = {1'b0, selN} + CNT_W'(carry);

  assign periodEnd = strobes.running && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeN <= '0;
      activeK <= '0;
      acc     <= '0;
      cnt     <= '0;
    end else if (strobes.apply) begin
      activeN <= selN;
      activeK <= selK;
      acc     <= accNext;
      cnt     <= lenNext;
    end else if (periodEnd) begin
      acc     <= accNext;
      cnt     <= lenNext;
    end else if (strobes.running && cnt != '0) begin
      cnt     <= cnt - CNT_W'(1);
    end
  end

  assign activeWord = {activeN, activeK};
endmodule

// File: rtl/fracn_divider.sv
module fracn_divider
  import fracn_pkg::*;
#(
  parameter int INT_W    = 13,
  parameter int FRAC_W   = 2,
  parameter int MIN_WORD = 2048
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrStrobe,
  input  logic [INT_W+FRAC_W-1:0] wrWord,
  input  logic                    cpBusy,
  input  logic                    testEn,
  output logic                    divPulse,
  output logic                    monOut
);
  localparam int WORD_W = INT_W + FRAC_W;

  divStrobes_t       strobes;
  logic [WORD_W-1:0] shadowWord;
  logic [WORD_W-1:0] activeWord;
  logic              periodEnd;

  fracn_ctrl #(.WORD_W(WORD_W), .MIN_WORD(MIN_WORD)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrStrobe   (wrStrobe),
    .wrWord     (wrWord),
    .cpBusy     (cpBusy),
    .periodEnd  (periodEnd),
    .strobes    (strobes),
    .shadowWord (shadowWord)
  );

  fracn_datapath #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .shadowWord (shadowWord),
    .periodEnd  (periodEnd),
    .activeWord (activeWord)
  );

  assign divPulse = periodEnd;
  assign monOut   = testEn & periodEnd;
endmodule

// File: rtl/fracn_divider_chk.sv
module fracn_divider_chk #(
  parameter int WORD_W   = 15,
  parameter int MIN_WORD = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrStrobe,
  input logic [WORD_W-1:0] wrWord,
  input logic              cpBusy,
  input logic              divPulse,
  input logic [WORD_W-1:0] shadowWord,
  input logic [WORD_W-1:0] activeWord
);
  logic seenValid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seenValid <= 1'b0;
    else if (wrStrobe && wrWord >= WORD_W'(MIN_WORD)) seenValid <= 1'b1;
  end

  p_silent_unprogrammed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seenValid |-> !divPulse);

  p_low_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStrobe && wrWord < WORD_W'(MIN_WORD)) |=> $stable(shadowWord));

  p_no_midperiod_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seenValid && !divPulse && activeWord != '0) |=> $stable(activeWord));

  p_busy_holds_setting_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpBusy |=> $stable(activeWord));

  p_single_cycle_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    divPulse |=> !divPulse);
endmodule

bind fracn_divider fracn_divider_chk #(.WORD_W(WORD_W), .MIN_WORD(MIN_WORD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wrStrobe   (wrStrobe),
  .wrWord     (wrWord),
  .cpBusy     (cpBusy),
  .divPulse   (divPulse),
  .shadowWord (shadowWord),
  .activeWord (activeWord)
);

// File: tb/fracn_divider_tb.sv
`timescale 1ns/1ps
module fracn_divider_tb;
  localparam int INT_W = 6;
  localparam int FRAC_W = 2;
  localparam int MIN_WORD = 12;
  localparam int WORD_W = INT_W + FRAC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrStrobe = 1'b0;
  logic [WORD_W-1:0] wrWord = '0;
  logic cpBusy = 1'b0;
  logic testEn = 1'b1;
  logic divPulse, monOut;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fracn_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_WORD(MIN_WORD)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .wrWord(wrWord),
    .cpBusy(cpBusy), .testEn(testEn), .divPulse(divPulse), .monOut(monOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural model: phase within the current period and its length
  int  mPhase = 0, mLen = 0, mN = 0, mK = 0, mAcc = 0, mShadow = 0;
  bit  mRun = 0, mPend = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mPhase = 0; mLen = 0; mN = 0; mK = 0; mAcc = 0; mShadow = 0;
      mRun = 0; mPend = 0;
    end else begin
      bit atEnd, doApply;
      atEnd   = mRun && (mPhase == mLen);
      doApply = mPend && !cpBusy && (!mRun || atEnd);
      if (doApply) begin
        mN = mShadow / 4; mK = mShadow % 4; mPend = 0; mRun = 1;
      end
      if (doApply || atEnd) begin
        mAcc = mAcc + mK;
        mLen = mN + (mAcc >= 4 ? 1 : 0);
        mAcc = mAcc % 4;
        mPhase = 1;
      end else if (mRun) begin
        mPhase = mPhase + 1;
      end
      if (wrStrobe && int'(wrWord) >= MIN_WORD) begin
        mShadow = int'(wrWord); mPend = 1;
      end
    end
  end

  // Cycle comparison of both outputs (R7, R8 and every other requirement)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit expP;
      expP = mRun && (mPhase == mLen);
      chk(divPulse === expP, "R7", "divPulse vs model", int'(divPulse), int'(expP));
      chk(monOut === (testEn && expP), "R8", "monOut vs model",
          int'(monOut), int'(testEn && expP));
    end
  end

  // Counts negedges until divPulse is seen; clears the write strobe
  task automatic waitPulse(output int interval);
    interval = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      wrStrobe = 1'b0;
      interval++;
      if (divPulse) return;
    end
    chk(1'b0, "R2", "pulse timeout", interval, 0);
  endtask

  task automatic measure(input int word, input int nPer, input string tag);
    int iv[$];
    int t;
    waitPulse(t);
    waitPulse(t);
    for (int i = 0; i < nPer; i++) begin
      waitPulse(t);
      iv.push_back(t);
      chk(t == word / 4 || t == word / 4 + 1, "R2", {tag, " interval"}, t, word / 4);
    end
    for (int i = 0; i + 3 < nPer; i++) begin
      int s;
      s = iv[i] + iv[i+1] + iv[i+2] + iv[i+3];
      chk(s == word, "R3", {tag, " four-period sum"}, s, word);
    end
  endtask

  task automatic writeWord(input int w);
    wrWord = WORD_W'(w);
    wrStrobe = 1'b1;
  endtask

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int t, cnt;
    repeat (4) @(negedge clk);
    chk(divPulse == 1'b0 && monOut == 1'b0, "R1", "reset state", int'(divPulse), 0);
    rst_n = 1'b1;

    // R1 and R4: a word below the minimum neither programs nor starts the divider
    @(negedge clk); writeWord(11);
    @(negedge clk); wrStrobe = 1'b0;
    cnt = 0;
    for (int i = 0; i < 120; i++) begin @(negedge clk); cnt += int'(divPulse); end
    chk(cnt == 0, "R1", "pulses before first valid write", cnt, 0);

    // R6: busy blocks the start of an idle divider
    cpBusy = 1'b1; writeWord(43);
    @(negedge clk); wrStrobe = 1'b0;
    cnt = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); cnt += int'(divPulse); end
    chk(cnt == 0, "R6", "start while busy", cnt, 0);
    cpBusy = 1'b0;

    measure(43, 12, "N=10 k=3");
    writeWord(29);  measure(29, 12, "N=7 k=1");
    writeWord(80);  measure(80, 8,  "N=20 k=0");
    writeWord(22);  measure(22, 12, "N=5 k=2");

    // R4: ignored write while running
    writeWord(9);   measure(22, 8, "after ignored write");
    chk(1'b1, "R4", "ignored write kept setting", 0, 0);

    // R5: write on a pulse edge does not cut the current period
    writeWord(120);
    waitPulse(t);
    chk(t == 5 || t == 6, "R5", "period after write keeps old length", t, 5);
    waitPulse(t);
    chk(t == 30, "R5", "first period of new setting", t, 30);

    // R6: deferral while busy at boundaries
    cpBusy = 1'b1; writeWord(36);
    waitPulse(t);
    waitPulse(t);
    chk(t == 30, "R6", "busy boundary keeps old setting", t, 30);
    waitPulse(t);
    chk(t == 30, "R6", "busy boundary keeps old setting", t, 30);
    cpBusy = 1'b0;
    waitPulse(t);
    waitPulse(t);
    chk(t == 9, "R6", "update applied after busy drops", t, 9);

    // R4 boundary: the minimum word itself is accepted
    writeWord(MIN_WORD); measure(MIN_WORD, 8, "minimum word");

    // R8: monitor silent with test disabled
    testEn = 1'b0; cnt = 0; t = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); cnt += int'(monOut); t += int'(divPulse);
    end
    chk(cnt == 0 && t > 0, "R8", "monOut with testEn low", cnt, 0);
    testEn = 1'b1;

    // Largest word: a period of N+1 = 64
    writeWord(255); measure(255, 12, "N=63 k=3");

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule